// File: doc/BRIEF.md
# Panel Timing Generator

This block turns a free-running oscillator clock into the timing that a 1/160-duty graphics panel needs. It produces a line strobe, an active-low frame signal, two row-driver level-select lines that walk a fixed 16-step pattern, a fast modulation clock for gray-level pulse shaping, and an active-low display-off output. A frame is split into two halves of 81 strobe periods each. The frame signal marks the first strobe of each half.

One device in a chain works in master mode and generates the strobe and frame signals. The others work in slave mode. They receive those two signals and keep only their level-select sequence and blanking state, so that they can be compared against the master. After a reset, or after a refresh request, the display is kept dark for four frames. This gives the panel time to settle before any image is shown.

Top module: `panel_timing_gen`

## Requirements
- R1: In master mode one strobe period lasts 16 clock cycles. The strobe is high for phases 0 to 7 and low for phases 8 to 15. Cycle index 0 is phase 0 of strobe 0.
- R2: A half frame holds 81 strobe periods and a frame holds 162 strobe periods (2592 cycles). After strobe 80 the line count returns to 0 and the next half begins at cycle 1296.
- R3: The active-low frame output is low for the whole of the first strobe period of each half (16 cycles) and high at all other times.
- R4: At strobe s, level-select A equals bit (s mod 16) of 16'h00FF and level-select B equals bit (s mod 16) of 16'h5AA5. The step count runs on across half and frame boundaries.
- R5: In master mode the modulation clock is high on even phases and low on odd phases.
- R6: While reset is asserted, the outputs are: strobe 0, frame 1, modulation clock 0, display-off 0, and both level-selects 1. After reset is released, cycle index 0 begins after the second rising clock edge.
- R7: The display-off output stays low for the first 4 frames (cycles 0 to 10367) with no request present, and rises at cycle 10368.
- R8: The display-off output (active low) is low whenever the request input (active high) is high. Outside the blanking window it follows the request.
- R9: A refresh request sampled high on an edge clears every counter, as reset does. The next cycle is cycle index 0, and the 4-frame blanking starts again. Refresh wins over a strobe or half-frame advance on the same edge.
- R10: In slave mode the strobe output is 0, the frame output is 1 and the modulation clock is 0.
- R11: In slave mode the level-select step advances once for each rising edge of the strobe input, and the new value is visible in the following cycle. Blanking ends on the eighth falling edge of the frame input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 selects master mode, 0 selects slave mode |
| dispoff_req | input | 1 | Display-off request, active high |
| refresh_req | input | 1 | Synchronous restart request, active high |
| strb_in | input | 1 | Strobe received from the master (slave mode) |
| frm_n_in | input | 1 | Active-low frame signal received from the master (slave mode) |
| strb_out | output | 1 | Generated line strobe |
| frm_n_out | output | 1 | Generated active-low frame signal |
| lsel_a | output | 1 | Row-driver level-select A |
| lsel_b | output | 1 | Row-driver level-select B |
| pwm_clk | output | 1 | Gray-level modulation clock |
| dispoff_n | output | 1 | Display-off output, active low |

## Verification
The delicate overlap is a refresh request on the last cycle of a half frame. On that edge the step counter, the line counter and the half flag would all advance. The bench raises refresh exactly at cycle 1295 of a half, when the step would move from 8 to 9. It then expects the following cycle to show the cycle-zero state: strobe high, frame low, both level-selects 1 and display-off low. No advanced value may appear. The same check confirms that blanking starts again from that point rather than staying released.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int unsigned STEP_LEN = 16;
  localparam logic [STEP_LEN-1:0] LSEL_A_PAT = 16'h00FF;
  localparam logic [STEP_LEN-1:0] LSEL_B_PAT = 16'h5AA5;
  typedef enum logic {MODE_SLAVE = 1'b0, MODE_MASTER = 1'b1} ptg_mode_e;
endpackage

// File: rtl/ptg_phase_div.sv
module ptg_phase_div #(
  parameter int unsigned PH_CYCLES = 16,
  localparam int unsigned PW = $clog2(PH_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ce,
  output logic [PW-1:0] ph,
  output logic          ph_last
);
  logic [PW-1:0] ph_d;

  assign ph_last = (ph == PW'(PH_CYCLES - 1));

  always_comb begin
    ph_d = ph;
    if (clr)     ph_d = '0;
    else if (ce) ph_d = ph_last ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph_d;
  end

  // R1: the phase wraps to zero after its last value
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_last && ce && !clr) |=> (ph == '0));
  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PW'(PH_CYCLES - 1));
endmodule

// File: rtl/ptg_line_seq.sv
module ptg_line_seq #(
  parameter int unsigned LINES = 81,
  parameter int unsigned STEP_LEN = 16,
  localparam int unsigned LW = $clog2(LINES),
  localparam int unsigned SW = $clog2(STEP_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          line_ce,
  input  logic          line_tick,
  input  logic          step_tick,
  output logic          line_zero,
  output logic          half_end,
  output logic [SW-1:0] step
);
  logic [LW-1:0] line, line_d;
  logic          half, half_d;
  logic [SW-1:0] step_d;
  logic          line_last, step_last;

  assign line_last = (line == LW'(LINES - 1));
  assign step_last = (step == SW'(STEP_LEN - 1));
  assign line_zero = (line == '0);
  assign half_end  = line_ce & line_tick & line_last;

  always_comb begin
    line_d = line;
    half_d = half;
    step_d = step;
    if (clr) begin
      line_d = '0;
      half_d = 1'b0;
      step_d = '0;
    end else begin
      if (line_ce && line_tick) begin
        line_d = line_last ? '0 : line + 1'b1;
        if (line_last) half_d = ~half;
      end
      if (step_tick) step_d = step_last ? '0 : step + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= '0;
      half <= 1'b0;
      step <= '0;
    end else begin
      line <= line_d;
      half <= half_d;
      step <= step_d;
    end
  end

  assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line <= LW'(LINES - 1));
  // R2: each wrap of the line count begins the other half
  assert_half_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !clr) |=> (half != $past(half)));
  // R4: the step count moves only on a tick
  assert_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_tick && !clr) |=> $stable(step));
endmodule

// File: rtl/ptg_blank.sv
module ptg_blank #(
  parameter int unsigned EVENTS = 8,
  localparam int unsigned CW = $clog2(EVENTS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  output logic blanking
);
  logic [CW-1:0] cnt, cnt_d;

  assign blanking = (cnt != CW'(EVENTS));

  always_comb begin
    cnt_d = cnt;
    if (clr)                  cnt_d = '0;
    else if (evt && blanking) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assert_blank_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(EVENTS));
  // R7: the window closes only after a counted event
  assert_blank_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blanking) |-> $past(evt));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import ptg_pkg::*;
#(
  parameter int unsigned PH_CYCLES      = 16,
  parameter int unsigned LINES_PER_HALF = 81,
  parameter int unsigned BLANK_FRAMES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_sel,
  input  logic dispoff_req,
  input  logic refresh_req,
  input  logic strb_in,
  input  logic frm_n_in,
  output logic strb_out,
  output logic frm_n_out,
  output logic lsel_a,
  output logic lsel_b,
  output logic pwm_clk,
  output logic dispoff_n
);
  localparam int unsigned PW           = $clog2(PH_CYCLES);
  localparam int unsigned SW           = $clog2(STEP_LEN);
  localparam int unsigned HIGH_CYCLES  = PH_CYCLES / 2;
  localparam int unsigned BLANK_EVENTS = 2 * BLANK_FRAMES;

  logic [1:0]    rs;
  logic          rst_int_n;
  ptg_mode_e     mode;
  logic          is_master, running;
  logic [PW-1:0] ph;
  logic          ph_last;
  logic          line_zero, half_end;
  logic [SW-1:0] step;
  logic          strb_q, strb_q_d, frm_q, frm_q_d;
  logic          strb_rise, frm_fall;
  logic          step_tick, blank_evt, blanking;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign rst_int_n = rs[1];

  assign mode      = ptg_mode_e'(master_sel);
  assign is_master = (mode == MODE_MASTER);
  assign running   = is_master & rst_int_n;

  // slave edge detection on the received timing
  always_comb begin
    strb_q_d = strb_q;
    frm_q_d  = frm_q;
    if (refresh_req) begin
      strb_q_d = 1'b0;
      frm_q_d  = 1'b1;
    end else if (!is_master) begin
      strb_q_d = strb_in;
      frm_q_d  = frm_n_in;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      strb_q <= 1'b0;
      frm_q  <= 1'b1;
    end else begin
      strb_q <= strb_q_d;
      frm_q  <= frm_q_d;
    end
  end

  assign strb_rise = ~is_master & strb_in & ~strb_q;
  assign frm_fall  = ~is_master & frm_q & ~frm_n_in;
  assign step_tick = is_master ? ph_last : strb_rise;
  assign blank_evt = is_master ? half_end : frm_fall;

  ptg_phase_div #(.PH_CYCLES(PH_CYCLES)) u_phase (
    .clk(clk), .rst_n(rst_int_n), .clr(refresh_req), .ce(is_master),
    .ph(ph), .ph_last(ph_last)
  );

  ptg_line_seq #(.LINES(LINES_PER_HALF), .STEP_LEN(STEP_LEN)) u_line (
    .clk(clk), .rst_n(rst_int_n), .clr(refresh_req), .line_ce(is_master),
    .line_tick(ph_last), .step_tick(step_tick),
    .line_zero(line_zero), .half_end(half_end), .step(step)
  );

  ptg_blank #(.EVENTS(BLANK_EVENTS)) u_blank (
    .clk(clk), .rst_n(rst_int_n), .clr(refresh_req), .evt(blank_evt),
    .blanking(blanking)
  );

  assign strb_out  = running & (ph < PW'(HIGH_CYCLES));
  assign frm_n_out = ~(running & line_zero);
  assign pwm_clk   = running & ~ph[0];
  assign lsel_a    = LSEL_A_PAT[step];
  assign lsel_b    = LSEL_B_PAT[step];
  assign dispoff_n = ~(dispoff_req | blanking);

  // R3: every frame pulse opens on a strobe high phase
  assert_frame_on_high_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(frm_n_out) |-> strb_out);
  // R1: a strobe rises right after the last phase
  assert_strobe_rise_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_master && ph_last && !refresh_req) |=> strb_out);
  // R11: each received strobe rise moves the step on
  assert_slave_step_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (strb_rise && !refresh_req) |=> (step != $past(step)));
  // R10: no generated timing leaves a slave
  assert_slave_idle_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !is_master |-> (!strb_out && frm_n_out && !pwm_clk));
endmodule

// File: tb/panel_timing_gen_tb.sv
`timescale 1ns/1ps
module panel_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic master_sel, dispoff_req, refresh_req, strb_in, frm_n_in;
  logic strb_out, frm_n_out, lsel_a, lsel_b, pwm_clk, dispoff_n;
  int   tests = 0;
  int   fails = 0;
  int   cur = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  panel_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .dispoff_req(dispoff_req),
    .refresh_req(refresh_req), .strb_in(strb_in), .frm_n_in(frm_n_in),
    .strb_out(strb_out), .frm_n_out(frm_n_out), .lsel_a(lsel_a), .lsel_b(lsel_b),
    .pwm_clk(pwm_clk), .dispoff_n(dispoff_n)
  );

  // {cycle index, strobe, frame_n, lsel_a, lsel_b, pwm, dispoff_n}
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {16'd0,     6'b101110}, {16'd7,     6'b101100}, {16'd8,     6'b001110},
    {16'd15,    6'b001100}, {16'd16,    6'b111010}, {16'd40,    6'b011110},
    {16'd128,   6'b110010}, {16'd195,   6'b110100}, {16'd1295,  6'b011100},
    {16'd1296,  6'b101010}, {16'd1311,  6'b001000}, {16'd1312,  6'b111110},
    {16'd2591,  6'b011000}, {16'd2592,  6'b101110}, {16'd2809,  6'b010000},
    {16'd10367, 6'b011100}, {16'd10368, 6'b100011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv_to(input int n);
    while (cur < n) begin
      @(negedge clk);
      cur++;
    end
  endtask

  task automatic start(input logic m);
    rst_n = 1'b0;
    master_sel = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cur = 0;
  endtask

  task automatic spulse(input int len);
    strb_in = 1'b1;
    repeat (len) @(negedge clk);
    strb_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic fpulse();
    frm_n_in = 1'b0;
    @(negedge clk);
    frm_n_in = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; master_sel = 1'b1; dispoff_req = 1'b0; refresh_req = 1'b0;
    strb_in = 1'b0; frm_n_in = 1'b1;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 strobe", strb_out, 0);
    chk("R6 frame", frm_n_out, 1);
    chk("R6 pwm", pwm_clk, 0);
    chk("R6 dispoff", dispoff_n, 0);
    chk("R6 lsel", {lsel_a, lsel_b}, 2'b11);
    start(1'b1);

    for (int i = 0; i < NV; i++) begin
      adv_to(int'(VEC[i][21:6]));
      chk("R1 strobe", strb_out, VEC[i][5]);
      chk("R3 frame", frm_n_out, VEC[i][4]);
      chk("R4 lsel_a", lsel_a, VEC[i][3]);
      chk("R4 lsel_b", lsel_b, VEC[i][2]);
      chk("R5 pwm", pwm_clk, VEC[i][1]);
      chk("R7 dispoff", dispoff_n, VEC[i][0]);
      if (VEC[i][21:6] == 16'd1296 || VEC[i][21:6] == 16'd2592)
        chk("R2 half start", frm_n_out, 0);
    end

    // R8 request after blanking ended
    dispoff_req = 1'b1; #1;
    chk("R8 request on", dispoff_n, 0);
    dispoff_req = 1'b0; #1;
    chk("R8 request off", dispoff_n, 1);

    // R9 refresh on the last cycle of a half (step 8 would become 9)
    adv_to(11663);
    chk("R9 pre line end", {strb_out, frm_n_out, lsel_a, lsel_b}, 4'b0100);
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
    cur = 0;
    chk("R9 restart", {strb_out, frm_n_out, lsel_a, lsel_b}, 4'b1011);
    chk("R9 blank again", dispoff_n, 0);
    adv_to(16);
    chk("R9 step one", {lsel_a, lsel_b}, 2'b10);
    adv_to(10367);
    chk("R9 blank end-1", dispoff_n, 0);
    adv_to(10368);
    chk("R9 blank end", dispoff_n, 1);

    // slave mode
    start(1'b0);
    chk("R10 idle", {strb_out, frm_n_out, pwm_clk}, 3'b010);
    chk("R11 step0", {lsel_a, lsel_b}, 2'b11);
    spulse(1);
    chk("R11 step1", {lsel_a, lsel_b}, 2'b10);
    spulse(5);
    chk("R11 long pulse once", {lsel_a, lsel_b}, 2'b11);
    for (int k = 0; k < 6; k++) spulse(1);
    chk("R11 step8", {lsel_a, lsel_b}, 2'b00);
    chk("R10 idle during", {strb_out, frm_n_out, pwm_clk}, 3'b010);
    for (int k = 0; k < 7; k++) fpulse();
    chk("R11 seven frames", dispoff_n, 0);
    fpulse();
    chk("R11 eight frames", dispoff_n, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule